// File: doc/BRIEF.md
# Staggered Multi-Domain Capture Controller

This controller sequences the at-speed capture of a design that has several clock domains with no skew management between them. The controller runs on the fastest clock. Each domain also supplies a full-rate tick enable. The controller produces a clock enable and a hold control for each domain, and one scan enable that all domains share. A pattern has three phases. First, the scan chains load under divided shift pulses. Next, the scan enable is dropped and allowed to settle. Last, the domains capture one at a time, in an order that is programmed again for each pattern.

While a domain captures, every other domain gets no state-changing clock edge. In suppression mode its clock is gated off. In hold mode its clock keeps running, but its hold control is raised. So a domain that feeds another never changes state while that other domain captures. Data a domain has captured then acts as stimulus for the domains that capture after it. Shift pulses can be staggered by one fast cycle per domain to spread switching current.

Top module: `stagger_capture_ctrl`

## Requirements
- R1: While reset is low, and on the first clock after it, all clock enables and hold controls are 0. The scan enable is 1, and the done and order-error flags are 0.
- R2: A start request in idle with a valid order starts the load phase. The load phase lasts SHIFT_LEN divider periods of DIV fast cycles. The scan enable stays 1 through idle and load.
- R3: In the load phase, with stagger on, domain d gets one shift pulse at divider phase d. With stagger off, every domain pulses at phase 0.
- R4: After the load phase, the scan enable goes to 0. SETTLE_CYC cycles follow in which no domain gets a pulse. The scan enable remains 0 while any capture pulse is output.
- R5: Capture slot s serves the domain whose 2-bit index sits at order bits [2s+1:2s]. That domain gets exactly one pulse, on its first tick in the slot. No other domain gets a pulse, and no domain captures twice in a pattern.
- R6: The order is latched at start, so successive patterns may capture in different orders.
- R7: In suppression mode (hold-mode input 0), each clock enable is 1 only for a pulse, and all hold controls are 0.
- R8: In hold mode (hold-mode input 1), all clock enables are 1, and each hold control is 1 except in a cycle where that domain pulses.
- R9: A start whose order is not a permutation of the domain indices sets the order-error flag. No pattern is started. The next valid start clears the flag.
- R10: Done is a one-cycle pulse. It follows only after every domain has captured once, and the controller then returns to idle.
- R11: A start request outside idle has no effect.
- R12: Every output is registered and follows the internal state one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fastest test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pattern start request |
| order_i | input | NUM_DOM*IDX_W | Capture order, slot s in bits [s*IDX_W +: IDX_W] |
| mode_hold_i | input | 1 | 1 = hold mode, 0 = clock suppression |
| stagger_i | input | 1 | 1 = stagger shift pulses by domain |
| dom_tick_i | input | NUM_DOM | Full-rate tick enable per domain |
| dom_clk_en_o | output | NUM_DOM | Clock enable per domain |
| dom_hold_o | output | NUM_DOM | Hold control per domain |
| scan_en_o | output | 1 | Shared scan enable |
| done_o | output | 1 | Pattern complete pulse |
| order_err_o | output | 1 | Last start carried an invalid order |

## Verification
Several properties are checked on every cycle. While the scan enable is low, at most one domain is active. No domain captures twice in a pattern, and done never fires before every domain has captured. Done lasts one cycle, capture pulses never coexist with a high scan enable, and a rejected order leaves the controller idle with the error flag set. Some behaviour shows only in the bench's scenarios, run against a reference model: the exact shift-pulse phases with stagger on and off, the settle gap length, the order of captures for several permutations in both modes, the error flag clearing, and start requests being ignored while busy.

// File: rtl/scc_pkg.sv
// Shared types for the staggered capture controller.
// Assumes: nothing beyond the encoding below.
package scc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_CAPT   = 3'd3,
        ST_FIN    = 3'd4
    } scc_state_e;
endpackage

// File: rtl/scc_perm_check.sv
// Checks that a packed order vector is a permutation of 0..NUM_DOM-1.
// Assumes: slot s lives in bits [s*IDX_W +: IDX_W]; purely combinational.
module scc_perm_check #(
    parameter int NUM_DOM = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_DOM*IDX_W-1:0] order_i,
    output logic                     perm_ok_o
);
    // Count occurrences of each domain index; each must appear exactly once.
    always_comb begin
        perm_ok_o = 1'b1;
        for (int v = 0; v < NUM_DOM; v++) begin
            int hits;
            hits = 0;
            for (int s = 0; s < NUM_DOM; s++) begin
                if (order_i[s*IDX_W +: IDX_W] == IDX_W'(v)) hits++;
            end
            if (hits != 1) perm_ok_o = 1'b0;
        end
    end
endmodule

// File: rtl/scc_shift_div.sv
// Shift clock divider for the load phase, with optional per-domain stagger.
// Assumes: DIV >= NUM_DOM so that staggered pulses fall in distinct phases;
// counters are cleared whenever run_i is low.
module scc_shift_div #(
    parameter int NUM_DOM   = 4,
    parameter int DIV       = 4,
    parameter int SHIFT_LEN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               stagger_i,
    output logic [NUM_DOM-1:0] shift_pulse_o,
    output logic               load_done_o
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int LEN_W = (SHIFT_LEN > 1) ? $clog2(SHIFT_LEN) : 1;

    logic [DIV_W-1:0] div_q;
    logic [LEN_W-1:0] len_q;
    logic             div_wrap;

    assign div_wrap    = (div_q == DIV_W'(DIV - 1));
    assign load_done_o = run_i && div_wrap && (len_q == LEN_W'(SHIFT_LEN - 1));

    // Advance divider phase and count completed shift periods.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
            len_q <= '0;
        end else begin
            div_q <= div_wrap ? '0 : div_q + 1'b1;
            if (div_wrap) len_q <= len_q + 1'b1;
        end
    end

    // One pulse per domain per period, at its own phase when staggered.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_pulse
        assign shift_pulse_o[d] = run_i &&
            (stagger_i ? (div_q == DIV_W'(d)) : (div_q == '0));
    end

    p_stagger_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && stagger_i) |-> $onehot0(shift_pulse_o));
endmodule

// File: rtl/stagger_capture_ctrl.sv
// Top of the staggered multi-domain capture controller.
// Sequences load, scan-enable settle and one-at-a-time domain capture in a
// per-pattern order, driving gated-clock enables or hold controls.
// Assumes: clk is the fastest clock; dom_tick_i are full-rate enables
// synchronous to clk; downstream gates use the registered outputs.
module stagger_capture_ctrl #(
    parameter int NUM_DOM    = 4,
    parameter int DIV        = 4,
    parameter int SHIFT_LEN  = 3,
    parameter int SETTLE_CYC = 2,
    parameter int IDX_W      = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_DOM*IDX_W-1:0] order_i,
    input  logic                     mode_hold_i,
    input  logic                     stagger_i,
    input  logic [NUM_DOM-1:0]       dom_tick_i,
    output logic [NUM_DOM-1:0]       dom_clk_en_o,
    output logic [NUM_DOM-1:0]       dom_hold_o,
    output logic                     scan_en_o,
    output logic                     done_o,
    output logic                     order_err_o
);
    import scc_pkg::*;

    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    scc_state_e               state_q;
    logic [NUM_DOM*IDX_W-1:0] order_q;
    logic [SET_W-1:0]         settle_q;
    logic [IDX_W-1:0]         slot_q;
    logic [IDX_W-1:0]         cur_dom;
    logic                     perm_ok;
    logic                     load_done;
    logic [NUM_DOM-1:0]       shift_pulse;
    logic [NUM_DOM-1:0]       cap_vec;
    logic [NUM_DOM-1:0]       pulse;
    logic [NUM_DOM-1:0]       seen_q;
    logic                     slot_last;
    logic                     settle_end;

    scc_perm_check #(.NUM_DOM(NUM_DOM), .IDX_W(IDX_W)) perm_i (
        .order_i   (order_i),
        .perm_ok_o (perm_ok)
    );

    scc_shift_div #(.NUM_DOM(NUM_DOM), .DIV(DIV), .SHIFT_LEN(SHIFT_LEN)) div_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_i         (state_q == ST_SHIFT),
        .stagger_i     (stagger_i),
        .shift_pulse_o (shift_pulse),
        .load_done_o   (load_done)
    );

    assign cur_dom    = order_q[slot_q*IDX_W +: IDX_W];
    assign slot_last  = (slot_q == IDX_W'(NUM_DOM - 1));
    assign settle_end = (settle_q == SET_W'(SETTLE_CYC - 1));

    // Capture pulse for the domain owning the current slot, on its tick.
    always_comb begin
        cap_vec = '0;
        if (state_q == ST_CAPT && dom_tick_i[cur_dom]) cap_vec[cur_dom] = 1'b1;
    end

    assign pulse = shift_pulse | cap_vec;

    // Pattern sequencer: idle, load, settle, capture slots, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            order_q  <= '0;
            settle_q <= '0;
            slot_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i && perm_ok) begin
                    order_q <= order_i;
                    state_q <= ST_SHIFT;
                end
                ST_SHIFT: if (load_done) state_q <= ST_SETTLE;
                ST_SETTLE: begin
                    settle_q <= settle_q + 1'b1;
                    if (settle_end) state_q <= ST_CAPT;
                end
                ST_CAPT: if (|cap_vec) begin
                    slot_q <= slot_q + 1'b1;
                    if (slot_last) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (state_q != ST_SETTLE) settle_q <= '0;
            if (state_q != ST_CAPT)   slot_q   <= '0;
        end
    end

    // Order-error flag, updated only by starts accepted in idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                            order_err_o <= 1'b0;
        else if (state_q == ST_IDLE && start_i) order_err_o <= !perm_ok;
    end

    // Registered output stage: enables, holds, scan enable, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_clk_en_o <= '0;
            dom_hold_o   <= '0;
            scan_en_o    <= 1'b1;
            done_o       <= 1'b0;
        end else begin
            dom_clk_en_o <= mode_hold_i ? '1 : pulse;
            dom_hold_o   <= mode_hold_i ? ~pulse : '0;
            scan_en_o    <= (state_q == ST_IDLE) || (state_q == ST_SHIFT);
            done_o       <= (state_q == ST_FIN);
        end
    end

    // Tracks which domains captured in this pattern (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) seen_q <= '0;
        else                              seen_q <= seen_q | cap_vec;
    end

    p_one_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en_o |-> $onehot0(dom_clk_en_o & ~dom_hold_o));
    p_capture_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT) |-> ((cap_vec & seen_q) == '0));
    p_capture_se_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cap_vec) |=> !scan_en_o);
    p_done_all_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&seen_q));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_bad_order_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !perm_ok) |=> (order_err_o && state_q == ST_IDLE));
endmodule

// File: tb/stagger_capture_ctrl_tb.sv
module stagger_capture_ctrl_tb_top;
    localparam int N = 4, DIV = 4, LEN = 3, SET = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0, stag = 1'b0;
    logic [7:0] order = 8'h00;
    logic [N-1:0] tick = '0;
    logic [N-1:0] en_o, hold_o;
    logic se_o, done_o, err_o;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    // Reference model state (0 idle,1 shift,2 settle,3 capt,4 fin)
    int m_st = 0, m_div = 0, m_cnt = 0, m_set = 0, m_slot = 0;
    int m_ord [N];
    logic [N-1:0] x_en = '0, x_hold = '0;
    logic x_se = 1, x_done = 0, x_err = 0;
    int phase_tag = 0;
    int capq [$];

    stagger_capture_ctrl #(.NUM_DOM(N), .DIV(DIV), .SHIFT_LEN(LEN), .SETTLE_CYC(SET)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .order_i(order),
        .mode_hold_i(mode), .stagger_i(stag), .dom_tick_i(tick),
        .dom_clk_en_o(en_o), .dom_hold_o(hold_o), .scan_en_o(se_o),
        .done_o(done_o), .order_err_o(err_o));

    always #5 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit is_perm(logic [7:0] o);
        int hits [N];
        for (int v = 0; v < N; v++) hits[v] = 0;
        for (int s = 0; s < N; s++) hits[o[2*s +: 2]]++;
        for (int v = 0; v < N; v++) if (hits[v] != 1) return 0;
        return 1;
    endfunction

    // One model step, mirroring what the outputs should hold after posedge.
    task automatic model_step();
        logic [N-1:0] p;
        int old;
        p = '0;
        if (!rst_n) begin
            m_st = 0; x_en = '0; x_hold = '0; x_se = 1; x_done = 0; x_err = 0;
            return;
        end
        old = m_st;
        phase_tag = old;
        case (old)
            0: if (start) begin
                x_err = !is_perm(order);
                if (is_perm(order)) begin
                    for (int s = 0; s < N; s++) m_ord[s] = order[2*s +: 2];
                    m_st = 1; m_div = 0; m_cnt = 0;
                end
            end
            1: begin
                for (int d = 0; d < N; d++) p[d] = stag ? (m_div == d) : (m_div == 0);
                if (m_div == DIV-1) begin
                    m_div = 0;
                    if (m_cnt == LEN-1) begin m_st = 2; m_set = 0; end
                    else m_cnt++;
                end else m_div++;
            end
            2: if (m_set == SET-1) begin m_st = 3; m_slot = 0; end else m_set++;
            3: if (tick[m_ord[m_slot]]) begin
                p[m_ord[m_slot]] = 1'b1;
                if (m_slot == N-1) m_st = 4; else m_slot++;
            end
            default: m_st = 0;
        endcase
        x_en   = mode ? '1 : p;
        x_hold = mode ? ~p : '0;
        x_se   = (old == 0) || (old == 1);
        x_done = (old == 4);
    endtask

    task automatic step();
        string en_req;
        model_step();
        @(negedge clk);
        case (phase_tag)
            1: en_req = "R3"; 2: en_req = "R4"; 3: en_req = "R5"; default: en_req = "R7";
        endcase
        if (!mode) chk(en_req, en_o, x_en); else chk("R8 en", en_o, x_en);
        chk("R8", hold_o, x_hold);
        chk("R2", se_o, x_se);
        chk("R10", done_o, x_done);
        chk("R9", err_o, x_err);
        if (!se_o && ((en_o & ~hold_o) != 0))
            for (int d = 0; d < N; d++) if ((en_o & ~hold_o) == (1 << d)) capq.push_back(d);
        cyc++;
        for (int d = 0; d < N; d++) tick[d] = ((cyc + d) % (d + 2)) == 0;
    endtask

    function automatic logic [7:0] pack(int a, int b, int c, int d);
        return {2'(d), 2'(c), 2'(b), 2'(a)};
    endfunction

    // Run one pattern; optionally pulse start again mid-load (R11).
    task automatic run_pattern(logic [7:0] o, logic md, logic sg, bit restart);
        int got_done;
        got_done = 0;
        capq.delete();
        order = o; mode = md; stag = sg; start = 1;
        step();
        start = 0;
        for (int i = 0; i < 200 && !got_done; i++) begin
            if (restart && i == 5) begin start = 1; order = pack(0, 0, 0, 0); end
            if (restart && i == 6) start = 0;
            step();
            if (done_o) got_done = 1;
        end
        chk("R10 done seen", got_done, 1);
        // R6: captures appear in the programmed order of this pattern
        chk("R6 count", capq.size(), N);
        for (int s = 0; s < N && s < capq.size(); s++) chk("R6 order", capq[s], o[2*s +: 2]);
        step();
        chk("R10 back to idle", se_o, 1);
    endtask

    initial begin
        for (int d = 0; d < N; d++) m_ord[d] = d;
        rst_n = 0;
        repeat (3) step();
        // R1: reset values, R12 registered outputs
        chk("R1 en", en_o, 0); chk("R1 hold", hold_o, 0);
        chk("R1 se", se_o, 1); chk("R1 done", done_o, 0); chk("R1 err", err_o, 0);
        rst_n = 1;
        step();
        chk("R12", se_o, 1);
        // R2 R3 R5 R7: suppression mode, staggered shifts
        run_pattern(pack(0, 1, 2, 3), 1'b0, 1'b1, 0);
        // R6 R8 R11: new order, hold mode, no stagger, start while busy
        run_pattern(pack(2, 0, 3, 1), 1'b1, 1'b0, 1);
        // R9: invalid order raises error and starts nothing
        order = pack(0, 0, 1, 2); mode = 0; start = 1;
        step();
        start = 0;
        repeat (6) step();
        chk("R9 err set", err_o, 1);
        chk("R9 stays idle", se_o, 1);
        chk("R9 no pulses", en_o, 0);
        // R9: valid start clears the flag; R4 settle gap observed by model
        run_pattern(pack(3, 2, 1, 0), 1'b0, 1'b1, 0);
        chk("R9 err cleared", err_o, 0);
        run_pattern(pack(1, 3, 0, 2), 1'b0, 1'b0, 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule